// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

The block keeps a small table of transmit descriptors in local registers. The CPU writes this table through a word-addressed slave port. The engine watches one table entry at a time without using the system bus. When that entry carries its ready flag, the engine takes the buffer address and the byte count from the entry. It then reads the frame from system memory through a request/acknowledge master port. The words go into an eight-word prefetch buffer.

The MAC transmitter is told to start only after the prefetch buffer holds eight words, or holds the whole frame if the frame is shorter. The engine then passes words to the MAC on a valid/ready stream and refills the buffer whenever a slot frees up. When the frame ends, the engine writes a completion code back into the entry and clears its ready flag, which returns the entry to the CPU. It then moves to the next entry, or back to entry 0 if the entry asked for that. If the buffer runs dry in the middle of a frame, the frame is aborted and marked as underrun.

Top module: `tx_desc_fetch`

## Requirements
- R1: After reset every table word reads as zero and `mem_req`, `tx_valid`, `tx_start` and `tx_abort` are low. A CPU write to word `cfg_addr` is visible on `cfg_rdata` when that address is selected. Entry n occupies word 2n (control/length) and word 2n+1 (buffer address).
- R2: While the current entry has its ready bit (bit 31 of the control word) clear, the engine issues no memory request and drives no transmit data.
- R3: Memory reads are made one at a time. The first read is at the buffer address and each following read is 4 bytes higher. `mem_req` and `mem_addr` stay unchanged until `mem_ack` is seen.
- R4: `tx_start` pulses once per frame with a nonzero length. It pulses only after min(8, ceil(length/4)) words have been acknowledged by memory, and before any data word is offered.
- R5: The MAC receives the frame words in address order. `tx_bytes` is 4 on every word except the last, where it is length mod 4 (or 4 if that is 0). `tx_last` is high only on the final word.
- R6: The buffer never holds more than 8 words. A new read is issued as soon as a slot is free and bytes remain.
- R7: On normal completion the control word is written back with bit 31 cleared and bit 17 (done) set. The wrap flag and the length (bits 15:0) are kept unchanged, and the address word is left untouched.
- R8: If the buffer is empty mid-frame and no word arrives in that cycle, `tx_abort` pulses and no further words of that frame are offered. The control word is written back with bit 31 cleared, bit 16 (underrun) set and bit 17 clear.
- R9: After an entry is finished, the engine moves to entry 0 if bit 30 (wrap) of that entry was set. Otherwise it moves to the next entry, modulo 8. Ready entries elsewhere in the table are not touched out of this order.
- R10: A ready entry with length 0 is completed as done without any memory request and without `tx_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr | input | 4 | Table word address |
| cfg_we | input | 1 | Table write strobe |
| cfg_wdata | input | 32 | Table write data |
| cfg_rdata | output | 32 | Table word at `cfg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_start | output | 1 | One-cycle pulse: frame transmission begins |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | MAC accepts the word |
| tx_data | output | 32 | Transmit word |
| tx_bytes | output | 3 | Valid bytes in the word (1 to 4) |
| tx_last | output | 1 | Final word of the frame |
| tx_abort | output | 1 | One-cycle pulse: frame aborted on underrun |

## Verification
A wrong buffer count or a wrong word counter shows up at the MAC stream within one word. It appears either as a data mismatch against the address-derived pattern or as a misplaced `tx_last`/`tx_bytes`. A wrong start threshold is caught on the `tx_start` cycle by counting memory acknowledges. A wrong entry index or a wrong write-back shows up only when the table is read back after the frame. Each frame's control word is therefore read and compared before the next frame is queued, and a decoy ready entry tests the wrap order.

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch #(
  parameter int ENTRIES   = 8,
  parameter int BUF_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(ENTRIES):0]      cfg_addr,
  input  logic                          cfg_we,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  output logic                          mem_req,
  output logic [31:0]                   mem_addr,
  input  logic                          mem_ack,
  input  logic [31:0]                   mem_rdata,
  output logic                          tx_start,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [31:0]                   tx_data,
  output logic [2:0]                    tx_bytes,
  output logic                          tx_last,
  output logic                          tx_abort
);
  localparam int IW = $clog2(ENTRIES);
  localparam int BW = $clog2(BUF_DEPTH);
  localparam int FW = BW + 1;

  typedef enum logic [2:0] {S_SCAN, S_FETCH, S_SEND, S_DRAIN, S_WB} st_t;

  st_t          st;
  logic [31:0]  dtab [2*ENTRIES];
  logic [IW-1:0] idx;
  logic [1:0]   len_lo;
  logic         wrap_f, under_f, req_q, start_q, abort_q;
  logic [14:0]  nw, issued, fetched, sent;
  logic [31:0]  next_addr, maddr;
  logic [31:0]  fifo [BUF_DEPTH];
  logic [BW-1:0] wp, rp;
  logic [FW-1:0] fill, fill_nxt;

  wire [31:0] w0     = dtab[{idx, 1'b0}];
  wire [14:0] nw_cur = 15'((17'(w0[15:0]) + 17'd3) >> 2);
  wire push          = req_q && mem_ack;
  wire pop           = (st == S_SEND) && (fill != '0) && tx_ready;
  wire all_fetched   = (fetched == nw);
  wire last_word     = (sent == nw - 15'd1);
  wire underrun      = (st == S_SEND) && (fill == '0) && !push;
  wire in_scan       = (st == S_SCAN);

  assign fill_nxt = fill + FW'(push) - FW'(pop);
  wire issue = ((st == S_FETCH) || (st == S_SEND)) && (!req_q || mem_ack) &&
               (issued != nw) && (fill_nxt < FW'(BUF_DEPTH));

  assign cfg_rdata = dtab[cfg_addr];
  assign mem_req   = req_q;
  assign mem_addr  = maddr;
  assign tx_start  = start_q;
  assign tx_abort  = abort_q;
  assign tx_valid  = (st == S_SEND) && (fill != '0);
  assign tx_data   = fifo[rp];
  assign tx_last   = last_word;
  assign tx_bytes  = (last_word && len_lo != 2'd0) ? {1'b0, len_lo} : 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*ENTRIES; i++) dtab[i] <= '0;
    end else begin
      if (st == S_WB)
        dtab[{idx, 1'b0}] <= (w0 & 32'h7FFC_FFFF) | {14'd0, ~under_f, under_f, 16'd0};
      if (cfg_we)
        dtab[cfg_addr] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SCAN; idx <= '0; len_lo <= '0; wrap_f <= 1'b0; under_f <= 1'b0;
      nw <= '0; issued <= '0; fetched <= '0; sent <= '0;
      next_addr <= '0; maddr <= '0; req_q <= 1'b0;
      start_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (push) begin
        req_q   <= 1'b0;
        fetched <= fetched + 15'd1;
      end
      if (issue) begin
        req_q     <= 1'b1;
        maddr     <= next_addr;
        next_addr <= next_addr + 32'd4;
        issued    <= issued + 15'd1;
      end
      if (pop) sent <= sent + 15'd1;
      case (st)
        S_SCAN: if (w0[31]) begin
          len_lo    <= w0[1:0];
          wrap_f    <= w0[30];
          nw        <= nw_cur;
          next_addr <= dtab[{idx, 1'b1}];
          issued    <= '0;
          fetched   <= '0;
          sent      <= '0;
          under_f   <= 1'b0;
          st        <= (nw_cur == '0) ? S_WB : S_FETCH;
        end
        S_FETCH: if (fill == FW'(BUF_DEPTH) || all_fetched) begin
          start_q <= 1'b1;
          st      <= S_SEND;
        end
        S_SEND: if (pop && last_word) st <= S_WB;
          else if (underrun) begin
            under_f <= 1'b1;
            abort_q <= 1'b1;
            st      <= S_DRAIN;
          end
        S_DRAIN: if (!req_q || mem_ack) st <= S_WB;
        S_WB: begin
          idx <= (wrap_f || idx == IW'(ENTRIES - 1)) ? '0 : idx + 1'b1;
          st  <= S_SCAN;
        end
        default: st <= S_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else if (in_scan) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (push) wp <= (wp == BW'(BUF_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == BW'(BUF_DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= mem_rdata;
  end
endmodule

// File: rtl/tx_desc_fetch_chk.sv
module tx_desc_fetch_chk #(
  parameter int BUF_DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mem_req,
  input logic                       mem_ack,
  input logic [31:0]                mem_addr,
  input logic                       tx_start,
  input logic                       tx_valid,
  input logic                       tx_abort,
  input logic [$clog2(BUF_DEPTH):0] fill,
  input logic                       all_fetched,
  input logic                       in_scan
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || mem_addr == $past(mem_addr) + 32'd4); // R3
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(BUF_DEPTH)+1)'(BUF_DEPTH)); // R6
  AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> fill == ($clog2(BUF_DEPTH)+1)'(BUF_DEPTH) || all_fetched); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_scan |-> !mem_req && !tx_valid); // R2
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_valid); // R8
endmodule

bind tx_desc_fetch tx_desc_fetch_chk #(.BUF_DEPTH(BUF_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .tx_start(tx_start), .tx_valid(tx_valid),
  .tx_abort(tx_abort), .fill(fill), .all_fetched(all_fetched), .in_scan(in_scan)
);

// File: tb/tx_desc_fetch_tb_top.sv
module tx_desc_fetch_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0]  cfg_addr = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        tx_start, tx_valid, tx_ready = 0, tx_last, tx_abort;
  logic [31:0] tx_data;
  logic [2:0]  tx_bytes;

  int checks = 0, fails = 0;
  int lat = 0, rdy_pct = 100, wcnt = 0;
  int k = 0, starts = 0, aborts = 0, acks = 0, mreqs = 0;
  int f_len = 0, f_nw = 0, exp_idx = 0;
  logic [31:0] f_ptr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tx_desc_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_start(tx_start), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_bytes(tx_bytes), .tx_last(tx_last), .tx_abort(tx_abort));

  function automatic logic [31:0] fdat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int exp_bytes(int n, int len, int kk);
    if (kk != n - 1 || len % 4 == 0) return 4;
    return len % 4;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_ack) wcnt = 0;
    mem_ack = 0;
    if (mem_req) begin
      mreqs++;
      if (wcnt >= lat) begin
        mem_ack = 1; mem_rdata = fdat(mem_addr); acks++;
      end else wcnt++;
    end
    tx_ready = ($urandom % 100) < rdy_pct;
    if (tx_start) begin
      starts++;
      chk(acks == (f_nw < 8 ? f_nw : 8), "R4", "words buffered at start", acks, (f_nw < 8 ? f_nw : 8));
    end
    if (tx_abort) aborts++;
    if (tx_valid && tx_ready) begin
      chk(tx_data == fdat(f_ptr + 4*k), "R5", "data", tx_data, fdat(f_ptr + 4*k));
      chk(tx_bytes == 3'(exp_bytes(f_nw, f_len, k)), "R5", "bytes", 32'(tx_bytes), exp_bytes(f_nw, f_len, k));
      chk(tx_last == (k == f_nw - 1), "R5", "last", 32'(tx_last), 32'(k == f_nw - 1));
      k++;
    end
  end

  task automatic cfg_write(int a, logic [31:0] d);
    @(negedge clk); cfg_addr = 4'(a); cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_read(int a, output logic [31:0] d);
    @(negedge clk); cfg_addr = 4'(a); #1 d = cfg_rdata;
  endtask

  task automatic run_frame(int len, bit wrap, logic [31:0] ptr, bit exp_under);
    logic [31:0] w, expw;
    int t = 0;
    k = 0; starts = 0; aborts = 0; acks = 0; mreqs = 0;
    f_len = len; f_nw = (len + 3) / 4; f_ptr = ptr;
    cfg_write(2*exp_idx + 1, ptr);
    cfg_write(2*exp_idx, {1'b1, wrap, 14'd0, 16'(len)});
    do begin cfg_read(2*exp_idx, w); t++; end while (w[31] && t < 5000);
    expw = {1'b0, wrap, 12'd0, ~exp_under, exp_under, 16'(len)};
    chk(w == expw, exp_under ? "R8" : "R7", "status word", w, expw);
    cfg_read(2*exp_idx + 1, w);
    chk(w == ptr, "R7", "address word kept", w, ptr);
    if (len == 0) begin
      chk(mreqs == 0, "R10", "memory requests", mreqs, 0);
      chk(starts == 0, "R10", "start pulses", starts, 0);
    end else if (exp_under) begin
      chk(aborts == 1, "R8", "abort pulses", aborts, 1);
      chk(k < f_nw, "R8", "words before abort", k, f_nw);
    end else begin
      chk(k == f_nw, "R5", "word count", k, f_nw);
      chk(starts == 1, "R4", "start pulses", starts, 1);
      chk(aborts == 0, "R8", "no abort", aborts, 0);
    end
    exp_idx = wrap ? 0 : (exp_idx + 1) % 8;
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(mem_req == 0 && tx_valid == 0 && tx_start == 0 && tx_abort == 0, "R1", "idle outputs in reset", 0, 0);
    rst_n = 1;
    for (int a = 0; a < 16; a++) begin
      cfg_read(a, w);
      chk(w == 0, "R1", "table word after reset", w, 0);
    end
    cfg_write(15, 32'hCAFE_1234);
    cfg_read(15, w);
    chk(w == 32'hCAFE_1234, "R1", "table readback", w, 32'hCAFE_1234);
    mreqs = 0;
    cfg_write(0, 32'h4000_0020);
    repeat (60) @(negedge clk);
    chk(mreqs == 0, "R2", "requests while not ready", mreqs, 0);

    run_frame(40, 0, 32'h0000_1000, 0);
    run_frame(5,  0, 32'h0000_2000, 0);
    run_frame(0,  0, 32'h0000_3000, 0);
    cfg_write(9, 32'h0000_9000);
    cfg_write(8, 32'h8000_0010);
    run_frame(12, 1, 32'h0000_4000, 0);
    chk(exp_idx == 0, "R9", "wrap target", exp_idx, 0);
    run_frame(33, 0, 32'h0000_5000, 0);
    cfg_read(8, w);
    chk(w == 32'h8000_0010, "R9", "decoy entry untouched", w, 32'h8000_0010);
    cfg_write(8, 32'h0);
    lat = 4;
    run_frame(64, 0, 32'h0000_6000, 1);
    lat = 0; rdy_pct = 70;
    for (int i = 0; i < 24; i++)
      run_frame(1 + $urandom % 100, ($urandom % 6) == 0, {16'h0001, 14'($urandom), 2'b00}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule